// File: doc/BRIEF.md
# Converter Status and Interrupt Register

This block holds the sixteen status bits of a three-channel data converter and the eight-bit mask that decides which of them raise the processor interrupt. Each converter channel reports a finished conversion through a one-cycle ready strobe. Other hardware events use event strobes, and informational conditions use flag strobes. Every strobe sets its own sticky bit. Only the low byte, ready bits and event bits together, can reach the single interrupt line, and each of its bits passes through its own mask bit. The high byte is visible to software but never interrupts.

Software reaches the block through a simple register bus made of an address, a read strobe, a write strobe, write data, and read data with a valid flag. The ready bits are not cleared by writing to the status register, which software cannot write at all. They clear as a side effect of fetching conversion data. A read of the primary channel's data address always clears them. A read of either secondary data address clears them only while the primary channel is disabled. The data words themselves belong to other logic, and this block returns zero for those addresses. Event and flag bits clear when software reads the status register. A read is answered by a small two-state response machine. It rests in S_IDLE. Any read moves it to S_RESP. It stays in S_RESP while reads continue back to back, and returns to S_IDLE on the first cycle without a read.

Top module: `cnv_stat_irq`

## Requirements
- R1: After reset, status, mask, irq, rvalid and rdata are all zero.
- R2: A strobe sets its sticky status bit at the next clock edge: rdy_set[i] sets bit i (bits 2:0), evt_set[j] sets bit 3+j (bits 7:3), flg_set[k] sets bit 8+k (bits 15:8).
- R3: irq is a register that becomes the OR over bits 7:0 of (status AND mask) one clock after the status and mask registers take those values.
- R4: Bits 15:8 never affect irq, whatever the mask holds.
- R5: Address 1 holds the mask in read-data bits 7:0, readable and writable, with bits 15:8 reading zero. Writes to address 0 (status) or to any other address change nothing.
- R6: A read sampled at a clock edge gives rvalid high in the next cycle, with rdata equal to the addressed value before that edge's update: address 0 gives status, address 1 gives the mask, and every other address gives zero. rvalid is low after a cycle without a read.
- R7: A read of address 2 (primary data) clears status bits 2:0.
- R8: While pri_en is low, a read of address 3 or 4 (secondary data) clears status bits 2:0.
- R9: While pri_en is high, a read of address 3 or 4 leaves status bits 2:0 unchanged.
- R10: A read of address 0 clears status bits 15:3 and leaves bits 2:0 unchanged.
- R11: When a set strobe arrives in the same cycle as a read that would clear its bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while rvalid is high |
| rvalid | output | 1 | Read response valid |
| pri_en | input | 1 | Primary channel enabled |
| rdy_set | input | 3 | Per-channel result-ready set strobes |
| evt_set | input | 5 | Low-byte event set strobes |
| flg_set | input | 8 | High-byte flag set strobes |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets the clear rule. It reads the secondary data addresses once with pri_en high and once with it low. A design that ignored the enable would either lose ready bits in the first case or keep them in the second. Strobes that arrive in the same cycle as a clearing read check whether clear wins over set, which would lose an event. With every mask bit enabled and only high-byte flags set, the bench confirms that irq stays low. Writes to the status address confirm that it cannot be written, and repeated reads back to back exercise the response machine's S_RESP self-loop.

// File: rtl/cnv_stat_pkg.sv
package cnv_stat_pkg;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } rd_state_e;

    localparam int unsigned ADR_STAT  = 0;
    localparam int unsigned ADR_MASK  = 1;
    localparam int unsigned ADR_DAT_P = 2;
    localparam int unsigned ADR_DAT_A = 3;
    localparam int unsigned ADR_DAT_B = 4;

endpackage

// File: rtl/cnv_stat_bus.sv
module cnv_stat_bus
    import cnv_stat_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LOW_W  = 8,
    parameter int N_RDY  = 3,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pri_en,
    input  logic [DATA_W-1:0] status_q,
    output logic [LOW_W-1:0]  mask_q,
    output logic [DATA_W-1:0] clr_vec,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    localparam int N_UPPER = DATA_W - N_RDY;

    rd_state_e state_q, state_d;
    logic hit_stat, hit_mask, hit_p, hit_a, hit_b;
    logic clr_rdy, clr_upper;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    // address decode
    always_comb begin
        hit_stat = (addr == ADDR_W'(ADR_STAT));
        hit_mask = (addr == ADDR_W'(ADR_MASK));
        hit_p    = (addr == ADDR_W'(ADR_DAT_P));
        hit_a    = (addr == ADDR_W'(ADR_DAT_A));
        hit_b    = (addr == ADDR_W'(ADR_DAT_B));
    end

    // clear-on-read rule: primary data always, secondaries only with primary off
    always_comb begin
        clr_rdy   = rd && (hit_p || (!pri_en && (hit_a || hit_b)));
        clr_upper = rd && hit_stat;
        clr_vec   = {{N_UPPER{clr_upper}}, {N_RDY{clr_rdy}}};
    end

    // mask register, software read/write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr && hit_mask) begin
            mask_q <= wdata[LOW_W-1:0];
        end
    end

    // read data selection
    always_comb begin
        if (hit_stat) begin
            rd_mux = status_q;
        end else if (hit_mask) begin
            rd_mux = DATA_W'(mask_q);
        end else begin
            rd_mux = '0;
        end
    end

    // response machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (rd) state_d = S_RESP;
            S_RESP:  if (!rd) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // response machine: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign rdata  = rdata_q;
    assign rvalid = (state_q == S_RESP);

endmodule

// File: rtl/cnv_stat_bits.sv
module cnv_stat_bits #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_vec,
    input  logic [DATA_W-1:0] clr_vec,
    output logic [DATA_W-1:0] status_q
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        // set has priority so a strobe meeting a clearing read is kept
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[b] <= 1'b0;
            end else if (set_vec[b]) begin
                status_q[b] <= 1'b1;
            end else if (clr_vec[b]) begin
                status_q[b] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cnv_stat_irq_gen.sv
module cnv_stat_irq_gen #(
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOW_W-1:0] src,
    input  logic [LOW_W-1:0] mask,
    output logic             irq
);

    logic [LOW_W-1:0] gated;

    for (genvar i = 0; i < LOW_W; i++) begin : g_gate
        assign gated[i] = src[i] & mask[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |gated;
        end
    end

endmodule

// File: rtl/cnv_stat_irq.sv
module cnv_stat_irq #(
    parameter int DATA_W = 16,
    parameter int LOW_W  = 8,
    parameter int N_RDY  = 3,
    parameter int ADDR_W = 3,
    localparam int N_EVT = LOW_W - N_RDY,
    localparam int HI_W  = DATA_W - LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic              pri_en,
    input  logic [N_RDY-1:0]  rdy_set,
    input  logic [N_EVT-1:0]  evt_set,
    input  logic [HI_W-1:0]   flg_set,
    output logic              irq
);

    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] set_vec;
    logic [LOW_W-1:0]  mask_q;

    assign set_vec = {flg_set, evt_set, rdy_set};

    cnv_stat_bus #(
        .DATA_W(DATA_W), .LOW_W(LOW_W), .N_RDY(N_RDY), .ADDR_W(ADDR_W)
    ) bus_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .pri_en(pri_en), .status_q(status_q),
        .mask_q(mask_q), .clr_vec(clr_vec), .rdata(rdata), .rvalid(rvalid)
    );

    cnv_stat_bits #(.DATA_W(DATA_W)) bits_i (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .status_q(status_q)
    );

    cnv_stat_irq_gen #(.LOW_W(LOW_W)) irq_i (
        .clk(clk), .rst_n(rst_n), .src(status_q[LOW_W-1:0]), .mask(mask_q),
        .irq(irq)
    );

endmodule

// File: rtl/cnv_stat_irq_chk.sv
module cnv_stat_irq_chk #(
    parameter int DATA_W = 16,
    parameter int LOW_W  = 8,
    parameter int N_RDY  = 3,
    parameter int ADDR_W = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         addr,
    input logic                      rd,
    input logic                      wr,
    input logic [DATA_W-1:0]         wdata,
    input logic                      pri_en,
    input logic [N_RDY-1:0]          rdy_set,
    input logic [LOW_W-N_RDY-1:0]    evt_set,
    input logic [DATA_W-LOW_W-1:0]   flg_set,
    input logic [DATA_W-1:0]         status_q,
    input logic [LOW_W-1:0]          mask_q,
    input logic                      irq,
    input logic                      rvalid
);

    logic [N_RDY-1:0] rdy_now;
    assign rdy_now = status_q[N_RDY-1:0];

    a_r3_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q[LOW_W-1:0] & mask_q) != '0) |=> irq);

    a_r4_high_byte_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[LOW_W-1:0] == '0) |=> !irq);

    a_r5_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(1)) |=> (mask_q == $past(wdata[LOW_W-1:0])));

    a_r6_rvalid_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);

    a_r6_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);

    a_r7_primary_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == ADDR_W'(2) && rdy_set == '0) |=> (rdy_now == '0));

    a_r8_fallback_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !pri_en && (addr == ADDR_W'(3) || addr == ADDR_W'(4)) && rdy_set == '0)
        |=> (rdy_now == '0));

    a_r9_secondary_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && pri_en && (addr == ADDR_W'(3) || addr == ADDR_W'(4)))
        |=> (rdy_now == ($past(rdy_now) | $past(rdy_set))));

    a_r10_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == ADDR_W'(0) && evt_set == '0 && flg_set == '0)
        |=> (status_q[DATA_W-1:N_RDY] == '0));

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_set[0] |=> status_q[0]);

endmodule

bind cnv_stat_irq cnv_stat_irq_chk #(
    .DATA_W(DATA_W), .LOW_W(LOW_W), .N_RDY(N_RDY), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .pri_en(pri_en), .rdy_set(rdy_set), .evt_set(evt_set), .flg_set(flg_set),
    .status_q(status_q), .mask_q(mask_q), .irq(irq), .rvalid(rvalid)
);

// File: tb/cnv_stat_irq_tb.sv
module cnv_stat_irq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rvalid;
    logic        pri_en = 1'b1;
    logic [2:0]  rdy_set = '0;
    logic [4:0]  evt_set = '0;
    logic [7:0]  flg_set = '0;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    string cur_req = "R1";
    bit done = 0;

    // reference model state
    logic [15:0] m_stat;
    logic [7:0]  m_mask;
    logic        m_irq, m_rv;
    logic [15:0] m_rdata;

    always #4 clk = ~clk;

    cnv_stat_irq dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .pri_en(pri_en),
        .rdy_set(rdy_set), .evt_set(evt_set), .flg_set(flg_set), .irq(irq)
    );

    // behavioural model, updated on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stat = '0; m_mask = '0; m_irq = 0; m_rv = 0; m_rdata = '0;
        end else begin
            logic [15:0] clr;
            logic nxt_irq;
            nxt_irq = |(m_stat[7:0] & m_mask);
            clr = '0;
            m_rv = rd;
            if (rd) begin
                case (addr)
                    3'd0: m_rdata = m_stat;
                    3'd1: m_rdata = {8'h00, m_mask};
                    default: m_rdata = 16'h0000;
                endcase
                if (addr == 3'd0) clr = clr | 16'hFFF8;
                if (addr == 3'd2) clr = clr | 16'h0007;
                if (!pri_en && (addr == 3'd3 || addr == 3'd4)) clr = clr | 16'h0007;
            end
            m_stat = (m_stat & ~clr) | {flg_set, evt_set, rdy_set};
            if (wr && addr == 3'd1) m_mask = wdata[7:0];
            m_irq = nxt_irq;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "irq", {15'd0, irq}, {15'd0, m_irq});
            chk(cur_req, "rvalid", {15'd0, rvalid}, {15'd0, m_rv});
            if (m_rv) chk(cur_req, "rdata", rdata, m_rdata);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // one bus/strobe cycle
    task automatic step(input logic r, input logic w, input logic [2:0] a,
                        input logic [15:0] d, input logic [2:0] rs,
                        input logic [4:0] es, input logic [7:0] fs);
        @(negedge clk);
        rd = r; wr = w; addr = a; wdata = d;
        rdy_set = rs; evt_set = es; flg_set = fs;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 3'd0, 16'h0, 3'h0, 5'h0, 8'h0);
    endtask

    task automatic rd_at(input logic [2:0] a);
        step(1, 0, a, 16'h0, 3'h0, 5'h0, 8'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        chk("R1", "irq in reset", {15'd0, irq}, 16'h0);
        chk("R1", "rvalid in reset", {15'd0, rvalid}, 16'h0);
        chk("R1", "rdata in reset", rdata, 16'h0);
        rst_n = 1'b1;
        cur_req = "R1";
        rd_at(3'd0); rd_at(3'd1); idle(1);

        // R5: mask read/write, status not writable, upper mask bits read zero
        cur_req = "R5";
        step(0, 1, 3'd1, 16'hFF5A, 3'h0, 5'h0, 8'h0);
        rd_at(3'd1); idle(1);
        chk("R5", "mask readback", rdata, 16'h005A);
        step(0, 1, 3'd0, 16'hFFFF, 3'h0, 5'h0, 8'h0);
        step(0, 1, 3'd5, 16'hFFFF, 3'h0, 5'h0, 8'h0);
        rd_at(3'd0); idle(1);
        chk("R5", "status unwritten", rdata, 16'h0000);
        rd_at(3'd1); idle(1);
        chk("R5", "mask after stray writes", rdata, 16'h005A);
        step(0, 1, 3'd1, 16'h0000, 3'h0, 5'h0, 8'h0);

        // R2: strobes set sticky bits
        cur_req = "R2";
        step(0, 0, 3'd0, 16'h0, 3'b101, 5'b10010, 8'h81);
        idle(2);
        rd_at(3'd0); idle(1);
        chk("R2", "sticky bits", rdata, 16'h8195);

        // R6: back-to-back reads and other addresses return zero
        cur_req = "R6";
        rd_at(3'd1); rd_at(3'd5); rd_at(3'd7); rd_at(3'd0); idle(2);

        // R3: interrupt from masked low byte
        cur_req = "R3";
        step(0, 1, 3'd1, 16'h0001, 3'h0, 5'h0, 8'h0);
        idle(3);
        chk("R3", "irq with masked ready", {15'd0, irq}, 16'h0001);
        step(0, 1, 3'd1, 16'h0002, 3'h0, 5'h0, 8'h0);
        idle(3);
        chk("R3", "irq masked off", {15'd0, irq}, 16'h0000);
        rd_at(3'd2); idle(1);

        // R4: high byte flags never interrupt even with full mask
        cur_req = "R4";
        step(0, 1, 3'd1, 16'h00FF, 3'h0, 5'h0, 8'h0);
        step(0, 0, 3'd0, 16'h0, 3'h0, 5'h0, 8'hFF);
        idle(4);
        chk("R4", "irq with flags only", {15'd0, irq}, 16'h0000);
        rd_at(3'd0); idle(2);

        // R9: primary enabled, secondary reads keep ready bits
        cur_req = "R9";
        pri_en = 1'b1;
        step(0, 0, 3'd0, 16'h0, 3'b111, 5'h0, 8'h0);
        rd_at(3'd3); rd_at(3'd4); idle(1);
        rd_at(3'd0); idle(1);
        chk("R9", "ready kept", rdata, 16'h0007);

        // R7: primary data read clears ready bits
        cur_req = "R7";
        rd_at(3'd2); idle(1);
        rd_at(3'd0); idle(1);
        chk("R7", "ready cleared", rdata, 16'h0000);

        // R8: primary disabled, each secondary read clears
        cur_req = "R8";
        pri_en = 1'b0;
        step(0, 0, 3'd0, 16'h0, 3'b110, 5'h0, 8'h0);
        rd_at(3'd3); idle(1);
        rd_at(3'd0); idle(1);
        chk("R8", "cleared via addr 3", rdata, 16'h0000);
        step(0, 0, 3'd0, 16'h0, 3'b011, 5'h0, 8'h0);
        rd_at(3'd4); idle(1);
        rd_at(3'd0); idle(1);
        chk("R8", "cleared via addr 4", rdata, 16'h0000);
        pri_en = 1'b1;

        // R10: status read clears events and flags, not ready bits
        cur_req = "R10";
        step(0, 0, 3'd0, 16'h0, 3'b010, 5'b00111, 8'h3C);
        idle(1);
        rd_at(3'd0); idle(1);
        chk("R10", "first status read", rdata, 16'h3C3A);
        rd_at(3'd0); idle(1);
        chk("R10", "second status read", rdata, 16'h0002);

        // R11: set strobe coinciding with clearing reads
        cur_req = "R11";
        step(1, 0, 3'd2, 16'h0, 3'b001, 5'h0, 8'h0);
        rd_at(3'd0); idle(1);
        chk("R11", "ready set during clear", rdata, 16'h0001);
        step(1, 0, 3'd0, 16'h0, 3'h0, 5'b00001, 8'h00);
        rd_at(3'd0); idle(1);
        chk("R11", "event set during status read", rdata, 16'h0009);
        rd_at(3'd2); idle(3);

        finish_run();
    end

endmodule